// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady time base from the system clock. A fixed divide-by-16 prescaler feeds a 20-bit running counter that climbs from zero to a programmed limit and then returns to zero. Each return to zero is one elapsed period. On each period the block adds one to a 12-bit count of elapsed periods and sets a status flag. A level interrupt is driven from that flag whenever software has enabled it.

Software reaches the block through a simple register bus. It programs the period and the two enables in a control word. It can then observe progress in two ways. The acknowledging snapshot returns the period count and the live counter value, and its read clears both the flag and the period count. The passive snapshot returns the same two fields and changes nothing. If the timer is switched off part way through a period, it finishes that period and parks at zero. This lets software stop the block cleanly and then wait for the counter to read zero.

Read data is combinational: it is valid during a cycle in which the read enable is high. The side effects of a read take place at the clock edge that ends that cycle.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and the counter does not advance while the run enable has never been set.
- R2: While running, the live counter advances by one every 16 clock cycles, so the first advance comes 16 edges after the edge that enables it.
- R3: A period lasts limit+1 prescaled ticks. At the tick where the counter equals the limit, it returns to zero, the period count rises by one and the status flag (offset 0x04, bit 0) is set.
- R4: The acknowledging snapshot at offset 0x08 returns the period count in bits 31:20 and the live counter in bits 19:0. At the end of that read the status flag and the period count are cleared.
- R5: The passive snapshot at offset 0x0C returns the same fields as R4 and leaves the status flag and the period count unchanged.
- R6: When the run enable is cleared, counting continues until the counter returns to zero, and the counter then holds at zero.
- R7: `irq` is high exactly while the status flag and the interrupt enable are both set. Clearing the interrupt enable lowers `irq` without clearing the flag.
- R8: The period count saturates at 4095 and does not wrap while no acknowledging read occurs.
- R9: If a period ends in the same cycle as an acknowledging read, the old state is cleared and the new period is recorded: the count becomes 1 and the flag stays set.
- R10: The control word at offset 0x00 holds the limit in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. It reads back with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; clear-on-read effects apply at the closing edge |
| bus_rdata | output | 32 | Read data, valid while `bus_re` is high |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can fall on the same cycle: the end of a period and an acknowledging read. The bench provokes this by programming a two-tick period and then issuing the acknowledging read on the last cycle before the fourth tick, so that the read's clearing edge is also the wrap edge. It judges the outcome by the value the read itself returns, which shows the state before the clear. It then uses a passive read and a status read to confirm that exactly one new period was kept and that the flag is still set.

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int PRESC_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int LIM_W = 20;
  localparam int OVF_W = 32 - LIM_W;

  logic [LIM_W-1:0]      lim_q, cur_q;
  logic [OVF_W-1:0]      ovf_q;
  logic [PRESC_BITS-1:0] div_q;
  logic                  run_en_q, int_en_q, sts_q;

  logic running, tick, wrap, ack_rd, ctl_wr;

  assign running = run_en_q | (cur_q != '0);
  assign tick    = running & (div_q == '1);
  assign wrap    = tick & (cur_q == lim_q);
  assign ack_rd  = bus_re & (bus_addr == 4'h8);
  assign ctl_wr  = bus_we & (bus_addr == 4'h0);
  assign irq     = sts_q & int_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q    <= '0;
      cur_q    <= '0;
      ovf_q    <= '0;
      div_q    <= '0;
      run_en_q <= 1'b0;
      int_en_q <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        lim_q    <= bus_wdata[LIM_W-1:0];
        run_en_q <= bus_wdata[24];
        int_en_q <= bus_wdata[25];
      end
      div_q <= running ? div_q + 1'b1 : '0;
      if (tick) cur_q <= wrap ? '0 : cur_q + 1'b1;
      if (ack_rd) begin
        ovf_q <= wrap ? OVF_W'(1) : '0;
        sts_q <= wrap;
      end else if (wrap) begin
        sts_q <= 1'b1;
        if (ovf_q != '1) ovf_q <= ovf_q + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        4'h0:       bus_rdata = {6'b0, int_en_q, run_en_q, 4'b0, lim_q};
        4'h4:       bus_rdata = {31'b0, sts_q};
        4'h8, 4'hC: bus_rdata = {ovf_q, cur_q};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_tick_timer_chk.sv
module interval_tick_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        int_en,
  input logic        sts,
  input logic        ack_rd,
  input logic        irq,
  input logic [19:0] cur,
  input logic [11:0] ovf,
  input logic [3:0]  div
);
  assert_adv_on_prescale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> $past(div) == 4'hF);

  assert_flag_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> cur == 20'd0);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ovf <= 12'd1);

  assert_park_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && cur == 20'd0) |=> cur == 20'd0);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(sts) || $rose(int_en)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == 12'hFFF && !ack_rd) |=> ovf == 12'hFFF);
endmodule

bind interval_tick_timer interval_tick_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en_q), .int_en(int_en_q), .sts(sts_q),
  .ack_rd(ack_rd), .irq(irq), .cur(cur_q), .ovf(ovf_q), .div(div_q)
);

// File: tb/interval_tick_timer_tb.sv
module interval_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq after reset", {31'b0, irq}, 0);
    rd(4'h0, d); chk("R1 control", d, 0);
    rd(4'h4, d); chk("R1 status", d, 0);
    rd(4'h8, d); chk("R1 ack snapshot", d, 0);
    idle(40);
    rd(4'hC, d); chk("R1 idle counter", d, 0);
  endtask

  task automatic t_control();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'hFCF1_2345);
    rd(4'h0, d); chk("R10 readback masks", d, 32'h0001_2345);
    idle(40);
    rd(4'hC, d); chk("R1 no run without enable", d, 0);
    wr(4'h0, 32'h0200_0005);
    rd(4'h0, d); chk("R10 interrupt enable bit", d, 32'h0200_0005);
  endtask

  task automatic t_period();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h0100_0003);
    idle(15);
    rd(4'hC, d); chk("R2 before first tick", d, 0);
    rd(4'hC, d); chk("R2 first tick", d, 1);
    idle(46);
    rd(4'hC, d); chk("R3 at limit", d, 3);
    rd(4'hC, d); chk("R3 wrap counts", d, {12'd1, 20'd0});
    rd(4'h4, d); chk("R3 flag set", d, 1);
    chk("R7 no irq when disabled", {31'b0, irq}, 0);
    rd(4'hC, d); chk("R5 passive keeps count", d, {12'd1, 20'd0});
    rd(4'h8, d); chk("R4 ack returns fields", d, {12'd1, 20'd0});
    rd(4'h4, d); chk("R4 flag cleared", d, 0);
    rd(4'hC, d); chk("R4 count cleared", d[31:20], 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h0300_0001);
    idle(31);
    chk("R7 irq low before wrap", {31'b0, irq}, 0);
    idle(1);
    chk("R7 irq high on wrap", {31'b0, irq}, 1);
    wr(4'h0, 32'h0100_0001);
    chk("R7 irq drops with enable", {31'b0, irq}, 0);
    rd(4'h4, d); chk("R7 flag kept", d, 1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h0100_0007);
    idle(47);
    wr(4'h0, 32'h0000_0007);
    idle(52);
    rd(4'hC, d); chk("R6 runs on after disable", d, 6);
    idle(27);
    rd(4'hC, d); chk("R6 finishes period", d, {12'd1, 20'd0});
    idle(100);
    rd(4'hC, d); chk("R6 parked at zero", d, {12'd1, 20'd0});
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h0100_0000);
    idle(16 * 4100);
    rd(4'hC, d); chk("R8 count saturates", d, {12'hFFF, 20'd0});
    rd(4'h8, d); chk("R8 ack at saturation", d, {12'hFFF, 20'd0});
    rd(4'hC, d); chk("R4 cleared after saturation", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    do_reset();
    wr(4'h0, 32'h0100_0001);
    idle(63);
    rd(4'h8, d); chk("R9 ack sees old state", d, {12'd1, 20'd1});
    rd(4'hC, d); chk("R9 new wrap kept", d, {12'd1, 20'd0});
    rd(4'h4, d); chk("R9 flag still set", d, 1);
  endtask

  initial begin
    t_reset();
    t_control();
    t_period();
    t_irq();
    t_disable();
    t_saturate();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule